// File: doc/BRIEF.md
# GPIO Bank Register File with Masked-Write Aliases

This block holds the pin-control state of one GPIO bank: 32 pins grouped as four ports of eight. A word-addressed register bus with separate read and write strobes reaches, for each port, an enable register, a direction register, an output-value register and a read-only input register. The block drives each pad's output value and output enable from these registers. Pad inputs pass through a two-stage synchronizer before software can read them.

Each writable register appears twice on the bus. The plain copy takes a full 8-bit replacement. The alias copy, placed a parameterized distance above it, takes a per-pin masked update. The write data carries a mask in one byte and new values in the byte below. Software can therefore flip single pins without a read-modify-write and without racing other writers of the same port. The interrupt register offsets belong to a separate interrupt block. This block reserves them, reads them as zero and ignores writes to them.

Top module: `gpio_mw_bank`

## Requirements
- R1: After a synchronous active-low reset, every enable, direction and output-value register reads 0, and `pad_out` and `pad_oe` are all 0.
- R2: A plain write replaces all 8 bits of the addressed register with `bus_wdata[7:0]`. The byte address is kind*0x10 + port*4, with kind 0 = enable, 1 = direction, 2 = output value. Bit n of port p controls pad p*8+n.
- R3: A write to the alias address (the plain address + `UPPER_OFS`) sets bit n of the register to `bus_wdata[n]` for each pin n whose mask bit `bus_wdata[8+n]` is 1.
- R4: On an alias write, every pin whose mask bit is 0 keeps its previous value.
- R5: A read at an alias address of a writable register returns the same value as a read at the plain address.
- R6: `pad_out` equals the output-value registers. `pad_oe[i]` is 1 only when both the enable bit and the direction bit of pad i are 1.
- R7: The input register at 0x30 + port*4 returns the pad levels through two flops. A read captured two edges after a pad change returns the old level, and a read one edge later returns the new level.
- R8: The input register is read-only. Writes to it, or to the place its alias would be, change no register, and it has no alias, so that alias address reads as 0.
- R9: Offsets 0x40–0x7C in both windows, and every address outside both windows, read as 0. Writes to them change no register.
- R10: `bus_rdata` loads on a clock edge where `bus_rd` is 1, in bits [7:0] with upper bits 0. It holds its value while `bus_rd` is 0.
- R11: The block works with both address layouts: stride 0x100 with alias offset 0x80, and stride 0x80 with alias offset 0x800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address within the bank's windows |
| bus_wdata | input | DATA_W | Write data; [15:8] is the mask and [7:0] the values on alias writes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |

## Verification
The bench targets alias writes with empty, full and random masks. A design that ignored the mask would clobber neighbouring pins, and one that swapped the bytes would write the mask as data. It writes garbage into the upper data bits of plain writes and checks that they are dropped. It also checks that the interrupt offsets, the input offset and the missing input alias neither store data nor echo it back, which a loose decoder would. Reads timed right at the synchronizer boundary expose a design with one stage too few or too many. A second instance with the far alias offset catches decode that hard-codes the near layout.

// File: rtl/gpio_mw_pkg.sv
// Shared definitions for the masked-write GPIO bank.
// Assumes four ports per bank and a fixed 0x10 spacing between register kinds.
package gpio_mw_pkg;
    localparam int NUM_PORTS   = 4;
    localparam int REG_SPAN    = 128;   // eight kinds * 0x10
    localparam int NUM_STORED  = 3;     // enable, direction, output value

    typedef enum logic [2:0] {
        K_EN   = 3'd0,
        K_DIR  = 3'd1,
        K_VAL  = 3'd2,
        K_IN   = 3'd3,
        K_IST  = 3'd4,
        K_IEN  = 3'd5,
        K_ITY  = 3'd6,
        K_ICLR = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        logic      masked;
        reg_kind_e kind;
        logic [1:0] port;
    } dec_t;

    function automatic int addr_bits(input int stride, input int upper);
        int top;
        top = (stride > upper + REG_SPAN) ? stride : upper + REG_SPAN;
        return $clog2(top);
    endfunction
endpackage

// File: rtl/gpio_mw_dec.sv
// Address decoder: classifies a byte address as plain, alias or unmapped,
// and extracts register kind and port. Assumes the alias window does not
// overlap the plain window.
module gpio_mw_dec
    import gpio_mw_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int UPPER_OFS = 128
)(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W:0] SPAN_END = (ADDR_W+1)'(REG_SPAN);
    localparam logic [ADDR_W:0] UP_LO    = (ADDR_W+1)'(UPPER_OFS);
    localparam logic [ADDR_W:0] UP_HI    = (ADDR_W+1)'(UPPER_OFS + REG_SPAN);

    logic              in_plain;
    logic              in_upper;
    logic [ADDR_W-1:0] off;
    logic              unused_off;

    // Window test and offset extraction.
    always_comb begin
        in_plain   = {1'b0, addr} < SPAN_END;
        in_upper   = !in_plain && ({1'b0, addr} >= UP_LO) && ({1'b0, addr} < UP_HI);
        off        = in_upper ? addr - UP_LO[ADDR_W-1:0] : addr;
        dec.kind   = reg_kind_e'(off[6:4]);
        dec.port   = off[3:2];
        dec.masked = in_upper;
        if (in_plain)
            dec.hit = (dec.kind == K_EN) || (dec.kind == K_DIR) ||
                      (dec.kind == K_VAL) || (dec.kind == K_IN);
        else if (in_upper)
            dec.hit = (dec.kind == K_EN) || (dec.kind == K_DIR) || (dec.kind == K_VAL);
        else
            dec.hit = 1'b0;
    end

    assign unused_off = ^{off[1:0], off[ADDR_W-1:7]};
endmodule

// File: rtl/gpio_mw_reg.sv
// One 8-bit pin register with plain (full) and masked (per-bit) update.
// Assumes wr_plain and wr_mask are never both high.
module gpio_mw_reg #(
    parameter int PINS = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_plain,
    input  logic              wr_mask,
    input  logic [2*PINS-1:0] wdata,
    output logic [PINS-1:0]   q
);
    logic [PINS-1:0] sel;
    logic [PINS-1:0] val;

    assign sel = wdata[2*PINS-1:PINS];
    assign val = wdata[PINS-1:0];

    // Register update: full replace or per-pin merge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_plain)
            q <= val;
        else if (wr_mask)
            q <= (q & ~sel) | (val & sel);
    end

    // R2
    plain_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_plain |=> q == $past(wdata[PINS-1:0]));
    // R3
    masked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (q & $past(wdata[2*PINS-1:PINS])) ==
                    ($past(wdata[PINS-1:0]) & $past(wdata[2*PINS-1:PINS])));
    // R4
    masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> ((q ^ $past(q)) & ~$past(wdata[2*PINS-1:PINS])) == '0);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_plain || wr_mask) |=> $stable(q));
endmodule

// File: rtl/gpio_mw_sync.sv
// Two-flop synchronizer for asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherency is given.
module gpio_mw_sync #(
    parameter int W = 32
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [1:0]   warm;

    // Two-stage capture of the pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

    // Counts edges since reset, for the latency check only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm <= '0;
        else if (warm != 2'd2)
            warm <= warm + 2'd1;
    end

    // R7
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2) |-> q == $past(d, 2));
endmodule

// File: rtl/gpio_mw_bank.sv
// Register file for one GPIO bank of four 8-pin ports with masked aliases.
// Assumes a single bank; bank selection happens upstream. Read data is
// registered on bus_rd.
module gpio_mw_bank
    import gpio_mw_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int DATA_W      = 32,
    parameter int BANK_STRIDE = 256,
    parameter int UPPER_OFS   = 128,
    localparam int ADDR_W     = addr_bits(BANK_STRIDE, UPPER_OFS),
    localparam int NPIN       = PINS * NUM_PORTS
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe
);
    dec_t            dec;
    logic [PINS-1:0] regq [NUM_STORED][NUM_PORTS];
    logic [NPIN-1:0] in_sync;
    logic [PINS-1:0] rd_val;
    logic            unused_wdata;

    gpio_mw_dec #(.ADDR_W(ADDR_W), .UPPER_OFS(UPPER_OFS)) dec_i (
        .addr (bus_addr),
        .dec  (dec)
    );

    gpio_mw_sync #(.W(NPIN)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (in_sync)
    );

    for (genvar k = 0; k < NUM_STORED; k++) begin : g_kind
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic sel;
            assign sel = bus_wr && dec.hit && (dec.kind == reg_kind_e'(k)) &&
                         (dec.port == 2'(p));
            gpio_mw_reg #(.PINS(PINS)) reg_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_plain (sel && !dec.masked),
                .wr_mask  (sel && dec.masked),
                .wdata    (bus_wdata[2*PINS-1:0]),
                .q        (regq[k][p])
            );
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pad
        assign pad_out[p*PINS +: PINS] = regq[K_VAL][p];
        assign pad_oe[p*PINS +: PINS]  = regq[K_EN][p] & regq[K_DIR][p];
    end

    // Read-data selection for the addressed register.
    always_comb begin
        rd_val = '0;
        if (dec.hit) begin
            if (dec.kind == K_IN)
                rd_val = in_sync[dec.port*PINS +: PINS];
            else
                rd_val = regq[dec.kind][dec.port];
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= {{(DATA_W-PINS){1'b0}}, rd_val};
    end

    assign unused_wdata = ^bus_wdata[DATA_W-1:2*PINS];

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !dec.hit) |=> bus_rdata == '0);
    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    // R6
    pad_oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~{regq[K_EN][3], regq[K_EN][2], regq[K_EN][1], regq[K_EN][0]}) == '0);
endmodule

// File: tb/gpio_mw_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_mw_bank_tb_top;
    localparam int A_W = 8;
    localparam int B_W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [A_W-1:0] a_addr = '0;
    logic [31:0] a_wdata = '0;
    logic        a_wr = 1'b0, a_rd = 1'b0;
    logic [31:0] a_rdata;
    logic [31:0] a_pin = '0, a_pout, a_poe;
    logic [B_W-1:0] b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic        b_wr = 1'b0, b_rd = 1'b0;
    logic [31:0] b_rdata;
    logic [31:0] b_pin = '0, b_pout, b_poe;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_reg [3][4];

    always #4 clk = ~clk;

    gpio_mw_bank #(.BANK_STRIDE(256), .UPPER_OFS(128)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wdata(a_wdata),
        .bus_wr(a_wr), .bus_rd(a_rd), .bus_rdata(a_rdata),
        .pad_in(a_pin), .pad_out(a_pout), .pad_oe(a_poe));

    gpio_mw_bank #(.BANK_STRIDE(128), .UPPER_OFS(2048)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wdata(b_wdata),
        .bus_wr(b_wr), .bus_rd(b_rd), .bus_rdata(b_rdata),
        .pad_in(b_pin), .pad_out(b_pout), .pad_oe(b_poe));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_out();
        return {m_reg[2][3], m_reg[2][2], m_reg[2][1], m_reg[2][0]};
    endfunction

    function automatic logic [31:0] exp_oe();
        logic [31:0] r;
        for (int p = 0; p < 4; p++) r[p*8 +: 8] = m_reg[0][p] & m_reg[1][p];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input int kind, input bit alias_w, input int port);
        if (kind < 3) return {24'h0, m_reg[kind][port]};
        if (kind == 3 && !alias_w) return {24'h0, a_pin[port*8 +: 8]};
        return 32'h0;
    endfunction

    function automatic logic [7:0] addr_of(input int kind, input bit alias_w, input int port);
        return 8'(kind*16 + port*4 + (alias_w ? 128 : 0));
    endfunction

    task automatic wr_a(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        a_addr = addr; a_wdata = data; a_wr = 1'b1;
        @(negedge clk);
        a_wr = 1'b0;
    endtask

    task automatic rd_a(input logic [7:0] addr, output logic [31:0] v);
        @(negedge clk);
        a_addr = addr; a_rd = 1'b1;
        @(negedge clk);
        a_rd = 1'b0;
        v = a_rdata;
    endtask

    task automatic wr_b(input logic [11:0] addr, input logic [31:0] data);
        @(negedge clk);
        b_addr = addr; b_wdata = data; b_wr = 1'b1;
        @(negedge clk);
        b_wr = 1'b0;
    endtask

    task automatic rd_b(input logic [11:0] addr, output logic [31:0] v);
        @(negedge clk);
        b_addr = addr; b_rd = 1'b1;
        @(negedge clk);
        b_rd = 1'b0;
        v = b_rdata;
    endtask

    // Model update for writes on instance A (kind 0..7, alias or plain).
    task automatic model_wr(input int kind, input bit alias_w, input int port, input logic [31:0] d);
        if (kind < 3) begin
            if (alias_w)
                m_reg[kind][port] = (m_reg[kind][port] & ~d[15:8]) | (d[7:0] & d[15:8]);
            else
                m_reg[kind][port] = d[7:0];
        end
    endtask

    task automatic chk_pads(input string tag);
        chk({tag, " pad_out"}, a_pout, exp_out());
        chk({tag, " pad_oe"}, a_poe, exp_oe());
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] d;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 3; k++) for (int p = 0; p < 4; p++) m_reg[k][p] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_pads("R1 reset");
        for (int k = 0; k < 3; k++) begin
            rd_a(addr_of(k, 0, 2), v);
            chk("R1 reset read", v, 32'h0);
        end

        // R2 plain write ignores upper data bits
        wr_a(addr_of(2, 0, 1), 32'hFFFF_A5C3); model_wr(2, 0, 1, 32'hFFFF_A5C3);
        chk_pads("R2 plain value");
        rd_a(addr_of(2, 0, 1), v);
        chk("R2 plain read", v, 32'h0000_00C3);

        // R6 direction without enable does not drive
        wr_a(addr_of(1, 0, 1), 32'h0000_00FF); model_wr(1, 0, 1, 32'hFF);
        chk("R6 oe needs enable", a_poe, 32'h0);
        wr_a(addr_of(0, 0, 1), 32'h0000_000F); model_wr(0, 0, 1, 32'h0F);
        chk("R6 oe gated", a_poe, 32'h0000_0F00);

        // R4 empty mask changes nothing
        wr_a(addr_of(2, 1, 1), 32'h0000_00FF); model_wr(2, 1, 1, 32'h0000_00FF);
        chk("R4 empty mask", a_pout, 32'h0000_C300);
        // R3 full mask replaces
        wr_a(addr_of(2, 1, 1), 32'h0000_FF18); model_wr(2, 1, 1, 32'h0000_FF18);
        chk("R3 full mask", a_pout, 32'h0000_1800);
        // R3 R4 single pin set
        wr_a(addr_of(2, 1, 1), 32'h0000_0101); model_wr(2, 1, 1, 32'h0000_0101);
        chk("R3 single pin", a_pout, 32'h0000_1900);
        // R5 alias read
        rd_a(addr_of(2, 1, 1), v);
        chk("R5 alias read", v, 32'h0000_0019);

        // R8 writes to input offset and its missing alias
        wr_a(addr_of(3, 0, 1), 32'h0000_FFFF);
        wr_a(addr_of(3, 1, 1), 32'h0000_FFFF);
        chk_pads("R8 input write");
        rd_a(addr_of(3, 1, 0), v);
        chk("R8 no input alias", v, 32'h0);

        // R10 hold while rd low
        rd_a(addr_of(2, 0, 1), v);
        @(negedge clk); a_addr = addr_of(2, 0, 0);
        @(negedge clk);
        chk("R10 hold", a_rdata, 32'h0000_0019);

        // R7 synchronizer boundary
        @(negedge clk); a_pin = 32'h5A00_0000;
        rd_a(addr_of(3, 0, 3), v);
        chk("R7 too early", v, 32'h0);
        rd_a(addr_of(3, 0, 3), v);
        chk("R7 settled", v, 32'h0000_005A);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op, kind, port;
            bit al;
            op = int'($urandom % 5);
            port = int'($urandom % 4);
            al = 1'($urandom % 2);
            d = $urandom;
            case (op)
                0: begin
                    kind = int'($urandom % 3);
                    wr_a(addr_of(kind, al, port), d); model_wr(kind, al, port, d);
                    chk_pads(al ? "R3 R4 R6 random" : "R2 R6 random");
                end
                1: begin
                    kind = int'($urandom % 8);
                    rd_a(addr_of(kind, al, port), v);
                    chk(kind >= 4 ? "R9 random read" : (al ? "R5 random read" : "R2 random read"),
                        v, exp_read(kind, al, port));
                end
                2: begin
                    @(negedge clk); a_pin = $urandom;
                    repeat (2) @(negedge clk);
                    rd_a(addr_of(3, 0, port), v);
                    chk("R7 random input", v, exp_read(3, 0, port));
                end
                3: begin
                    kind = 3 + int'($urandom % 5);
                    wr_a(addr_of(kind, al, port), d);
                    chk_pads("R9 reserved write");
                    rd_a(addr_of(int'($urandom % 3), 0, port), v);
                end
                default: begin
                    kind = int'($urandom % 3);
                    wr_a(addr_of(kind, 1, port), {16'h0, 8'h00, d[7:0]});
                    chk_pads("R4 zero mask");
                end
            endcase
        end

        // R11 second layout
        wr_b(12'h800 + 12'h024, 32'h0000_F0A0);
        chk("R11 far alias write", b_pout, 32'h0000_A000);
        rd_b(12'h024, v);
        chk("R11 plain read", v, 32'h0000_00A0);
        rd_b(12'h824, v);
        chk("R11 alias read", v, 32'h0000_00A0);
        wr_b(12'h424, 32'h0000_FFFF);
        chk("R11 R9 gap write", b_pout, 32'h0000_A000);
        rd_b(12'h400, v);
        chk("R11 R9 gap read", v, 32'h0);

        finish_run();
    end
endmodule